// File: doc/BRIEF.md
# Open-Drain Serial Clock Pacer

This block paces the clock wire of a two-wire serial bus that uses open-drain signalling. It never drives the wire high. It only asserts a pull-low enable. When the enable is dropped, the external pull-up raises the wire. The block can run a free-running clock. It can also make one falling or one rising transition when asked. Every level it commands is kept for at least `MIN_STABLE_CYCLES` system clocks.

Phase timing starts from the wire level as actually observed at the pad, not from the block's own enable. As a result, a device that holds the wire low after the block has released it stretches the clock, and the following high phase still gets its full length. When a released wire does not come up for a full minimum phase, the block raises a stuck-low flag. The flag drops once a rising edge is seen. The pad buffer, the input synchroniser and the edge detector sit outside the block. They deliver the observed level and one-cycle rise and fall pulses.

Top module: `scl_pacer`

## Requirements
- R1: While `rst_n` is low, `pull_low_o` is 0 (wire released) and `stuck_o` is 0, and all timers and pending requests are cleared.
- R2: With `run_i` high and a wire that follows the enable, `pull_low_o` alternates on its own. Each level lasts `MIN_STABLE_CYCLES`+2 clocks, because the level is held until `MIN_STABLE_CYCLES` clocks have passed after the observed edge.
- R3: A one-cycle `fall_req_i` pulse given while the line is released, high and settled sets `pull_low_o` to 1 at the next clock edge. The enable then stays 1 while no further request or run is present.
- R4: A one-cycle `rise_req_i` pulse given while the line is pulled low and settled clears `pull_low_o` at the next clock edge.
- R5: A request for the level already commanded (a rise request while released, a fall request while pulled low) is dropped and has no later effect.
- R6: A request that arrives before the current phase has settled is kept pending. It is carried out on the first clock at which the phase has lasted `MIN_STABLE_CYCLES` clocks after the observed edge.
- R7: `pull_low_o` never goes from 0 to 1 while the observed line is low. After a stretched low phase ends, the next pull-low comes `MIN_STABLE_CYCLES`+1 clocks after the rising edge is seen, so the high phase is not shortened.
- R8: When the line is released but stays low, `stuck_o` rises at the (`MIN_STABLE_CYCLES`+1)-th clock edge after the release. It falls at the clock edge where a rising-edge pulse is seen, and it is never 1 while `pull_low_o` is 1.
- R9: With `run_i` low and no request pending, `pull_low_o` holds its value.
- R10: `pull_low_o` changes only after at least `MIN_STABLE_CYCLES` consecutive clocks in which no edge pulse and no change of the enable occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_lvl_i | input | 1 | Observed clock-wire level from the pad |
| line_rise_i | input | 1 | One-cycle pulse: observed wire went high |
| line_fall_i | input | 1 | One-cycle pulse: observed wire went low |
| run_i | input | 1 | Free-running clock enable |
| rise_req_i | input | 1 | One-cycle request for a single rising transition |
| fall_req_i | input | 1 | One-cycle request for a single falling transition |
| pull_low_o | output | 1 | 1 pulls the clock wire low, 0 releases it |
| stuck_o | output | 1 | Released wire failed to rise within a minimum phase |

## Verification
The bench models the pad as a wired-AND of the block's enable and a simulated device that can hold the wire low. The edge pulses are derived one cycle later, as a real detector would produce them.

The block is driven with these input patterns:
- **Single requests on a settled line** show that the transition happens on the very next edge.
- **Requests issued mid-phase** separate the pending behaviour from immediate action.
- **Requests for the current level** show that they are dropped rather than remembered.
- **Free-running mode** measures the exact phase lengths.
- **Holding the released wire low** separates stretch-aware timing from timing based on the block's own output, and pins the cycles at which the stuck flag sets and clears.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

  // Commanded level of the open-drain clock wire.
  typedef enum logic {
    WIRE_RELEASED = 1'b0,
    WIRE_PULLED   = 1'b1
  } wire_cmd_e;

  // Width needed to count from 0 up to and including lim.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/scl_pacer_timer.sv
module scl_pacer_timer #(
  parameter int unsigned MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen_i,
  input  logic own_change_i,
  output logic settled_o
);
  import scl_pacer_pkg::*;

  localparam int unsigned CW = cnt_width(MIN_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Restart on any observed edge or own command change; saturate at LIMIT.
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (edge_seen_i || own_change_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // An edge seen this cycle starts a fresh phase, so the old count is void.
  assign settled_o = (cnt_q == LIMIT) && !edge_seen_i;

endmodule

// File: rtl/scl_pacer_drive.sv
module scl_pacer_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic rise_req_i,
  input  logic fall_req_i,
  input  logic settled_i,
  input  logic line_lvl_i,
  output logic pull_low_o,
  output logic change_o
);
  import scl_pacer_pkg::*;

  wire_cmd_e cmd_q, cmd_d;
  logic      pend_rise_q, pend_rise_d;
  logic      pend_fall_q, pend_fall_d;
  logic      want_rise, want_fall, do_rise, do_fall;

  always_comb begin
    want_rise = run_i | rise_req_i | pend_rise_q;
    want_fall = run_i | fall_req_i | pend_fall_q;
    do_rise   = (cmd_q == WIRE_PULLED)   && want_rise && settled_i;
    // Never pull while someone else already holds the wire low.
    do_fall   = (cmd_q == WIRE_RELEASED) && want_fall && settled_i && line_lvl_i;

    cmd_d = cmd_q;
    if (do_rise) cmd_d = WIRE_RELEASED;
    if (do_fall) cmd_d = WIRE_PULLED;

    // A request only survives while it asks for the other level.
    pend_rise_d = (cmd_q == WIRE_PULLED)   && !do_rise && (pend_rise_q || rise_req_i);
    pend_fall_d = (cmd_q == WIRE_RELEASED) && !do_fall && (pend_fall_q || fall_req_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= WIRE_RELEASED;
      pend_rise_q <= 1'b0;
      pend_fall_q <= 1'b0;
    end else begin
      cmd_q       <= cmd_d;
      pend_rise_q <= pend_rise_d;
      pend_fall_q <= pend_fall_d;
    end
  end

  assign pull_low_o = (cmd_q == WIRE_PULLED);
  assign change_o   = do_rise | do_fall;

endmodule

// File: rtl/scl_pacer_stuck.sv
module scl_pacer_stuck #(
  parameter int unsigned MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pull_low_i,
  input  logic line_lvl_i,
  input  logic line_rise_i,
  output logic stuck_o
);
  import scl_pacer_pkg::*;

  localparam int unsigned CW = cnt_width(MIN_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CYCLES);

  logic [CW-1:0] low_cnt_q, low_cnt_d;
  logic          low_cnt_en;
  logic          flag_q, flag_d;

  always_comb begin
    low_cnt_en = 1'b0;
    low_cnt_d  = low_cnt_q;
    if (pull_low_i || line_rise_i || line_lvl_i) begin
      low_cnt_en = (low_cnt_q != '0);
      low_cnt_d  = '0;
    end else if (low_cnt_q != LIMIT) begin
      low_cnt_en = 1'b1;
      low_cnt_d  = low_cnt_q + 1'b1;
    end

    flag_d = flag_q;
    if (line_rise_i)                            flag_d = 1'b0;
    else if (!pull_low_i && low_cnt_q == LIMIT) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (low_cnt_en) low_cnt_q <= low_cnt_d;
      flag_q <= flag_d;
    end
  end

  assign stuck_o = flag_q;

endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
  parameter int unsigned MIN_STABLE_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_lvl_i,
  input  logic line_rise_i,
  input  logic line_fall_i,
  input  logic run_i,
  input  logic rise_req_i,
  input  logic fall_req_i,
  output logic pull_low_o,
  output logic stuck_o
);

  logic edge_seen;
  logic own_change;
  logic settled;

  assign edge_seen = line_rise_i | line_fall_i;

  scl_pacer_timer #(
    .MIN_CYCLES (MIN_STABLE_CYCLES)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .edge_seen_i  (edge_seen),
    .own_change_i (own_change),
    .settled_o    (settled)
  );

  scl_pacer_drive u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .rise_req_i (rise_req_i),
    .fall_req_i (fall_req_i),
    .settled_i  (settled),
    .line_lvl_i (line_lvl_i),
    .pull_low_o (pull_low_o),
    .change_o   (own_change)
  );

  scl_pacer_stuck #(
    .MIN_CYCLES (MIN_STABLE_CYCLES)
  ) u_stuck (
    .clk         (clk),
    .rst_n       (rst_n),
    .pull_low_i  (pull_low_o),
    .line_lvl_i  (line_lvl_i),
    .line_rise_i (line_rise_i),
    .stuck_o     (stuck_o)
  );

endmodule

// File: rtl/scl_pacer_chk.sv
module scl_pacer_chk #(
  parameter int unsigned MIN_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic line_lvl_i,
  input logic line_rise_i,
  input logic line_fall_i,
  input logic pull_low_o,
  input logic stuck_o
);
  import scl_pacer_pkg::*;

  localparam int unsigned CW = cnt_width(MIN_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CYCLES);

  // Independent count of quiet cycles: no edge pulse, no enable change.
  logic [CW-1:0] quiet_q;
  logic          pull_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q     <= '0;
      pull_seen_q <= 1'b0;
    end else begin
      pull_seen_q <= pull_low_o;
      if (line_rise_i || line_fall_i || (pull_low_o != pull_seen_q)) quiet_q <= '0;
      else if (quiet_q != LIMIT)                                     quiet_q <= quiet_q + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!pull_low_o && !stuck_o));                                   // R1

  AST_MIN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_low_o != $past(pull_low_o)) |-> ($past(quiet_q) == LIMIT));         // R10

  AST_NO_PULL_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_low_o) |-> $past(line_lvl_i));                                // R7

  AST_STUCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    line_rise_i |=> !stuck_o);                                               // R8

  AST_STUCK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_o |-> !pull_low_o);                                                // R8

endmodule

bind scl_pacer scl_pacer_chk #(
  .MIN_CYCLES (MIN_STABLE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_lvl_i  (line_lvl_i),
  .line_rise_i (line_rise_i),
  .line_fall_i (line_fall_i),
  .pull_low_o  (pull_low_o),
  .stuck_o     (stuck_o)
);

// File: tb/scl_pacer_tb.sv
module scl_pacer_tb;

  localparam int  MIN      = 4;
  localparam time CLK_PER  = 10;
  localparam int  N_VEC    = 14;
  localparam int  WDOG_MAX = 5000;

  // Vector: {run, rise_req, fall_req, wait_cycles[7:0], exp_pull, exp_stuck}
  typedef struct packed {
    logic       run;
    logic       rr;
    logic       rf;
    logic [7:0] wt;
    logic       exp_pull;
    logic       exp_stuck;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{1'b0, 1'b0, 1'b0, 8'd8,  1'b0, 1'b0},  // R9 idle holds released
    '{1'b0, 1'b0, 1'b1, 8'd1,  1'b1, 1'b0},  // R3 fall on settled line
    '{1'b0, 1'b1, 1'b0, 8'd1,  1'b1, 1'b0},  // R6 early rise kept pending
    '{1'b0, 1'b0, 1'b0, 8'd4,  1'b1, 1'b0},  // R6 not yet carried out
    '{1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 1'b0},  // R6 carried out when settled
    '{1'b0, 1'b1, 1'b0, 8'd10, 1'b0, 1'b0},  // R5 rise while released dropped
    '{1'b0, 1'b0, 1'b1, 8'd1,  1'b1, 1'b0},  // R3 fall again
    '{1'b0, 1'b0, 1'b0, 8'd12, 1'b1, 1'b0},  // R5 dropped rise never acts
    '{1'b0, 1'b1, 1'b0, 8'd1,  1'b0, 1'b0},  // R4 rise on settled low
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b0, 1'b0},  // R2 run starts, high phase
    '{1'b1, 1'b0, 1'b0, 8'd4,  1'b0, 1'b0},  // R2 still high
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1, 1'b0},  // R2 falls after MIN+2
    '{1'b1, 1'b0, 1'b0, 8'd5,  1'b1, 1'b0},  // R2 still low
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b0, 1'b0}   // R2 rises after MIN+2
  };

  function automatic string vec_req(input int idx);
    case (idx)
      0:             return "R9";
      1, 6:          return "R3";
      2, 3, 4:       return "R6";
      5, 7:          return "R5";
      8:             return "R4";
      default:       return "R2";
    endcase
  endfunction

  logic clk, rst_n;
  logic run, rise_req, fall_req;
  logic hold;
  logic line_lvl, line_rise, line_fall;
  logic pull_low, stuck;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  scl_pacer #(.MIN_STABLE_CYCLES(MIN)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_lvl_i  (line_lvl),
    .line_rise_i (line_rise),
    .line_fall_i (line_fall),
    .run_i       (run),
    .rise_req_i  (rise_req),
    .fall_req_i  (fall_req),
    .pull_low_o  (pull_low),
    .stuck_o     (stuck)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  // Pad model: wired-AND with a device that may hold the wire low,
  // edge pulses produced by a detector one cycle behind.
  initial begin
    line_lvl  = 1'b1;
    line_rise = 1'b0;
    line_fall = 1'b0;
  end
  always @(negedge clk) begin
    line_lvl  <= ~(pull_low | hold);
    line_rise <= ~(pull_low | hold) & ~line_lvl;
    line_fall <=  (pull_low | hold) &  line_lvl;
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      #2;
      rise_req = 1'b0;
      fall_req = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WDOG_MAX; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; rise_req = 1'b0; fall_req = 1'b0; hold = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset pull", pull_low, 1'b0);
    check("R1 reset stuck", stuck, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      run      = VECS[i].run;
      rise_req = VECS[i].rr;
      fall_req = VECS[i].rf;
      step(int'(VECS[i].wt));
      check($sformatf("%s vector %0d pull", vec_req(i), i), pull_low, VECS[i].exp_pull);
      check($sformatf("%s vector %0d stuck", vec_req(i), i), stuck, VECS[i].exp_stuck);
    end

    // Just released with run on: another device now holds the wire low.
    hold = 1'b1;
    step(4);
    check("R8 stuck not yet", stuck, 1'b0);
    check("R7 no pull during stretch", pull_low, 1'b0);
    step(1);
    check("R8 stuck set", stuck, 1'b1);
    step(15);
    check("R8 stuck held", stuck, 1'b1);
    check("R7 still no pull", pull_low, 1'b0);
    hold = 1'b0;
    step(1);
    check("R8 stuck cleared on rise", stuck, 1'b0);
    check("R7 no pull at rise", pull_low, 1'b0);
    step(4);
    check("R7 high phase not shortened", pull_low, 1'b0);
    step(1);
    check("R7 pull after full high phase", pull_low, 1'b1);

    // Reset while pulled low.
    #1;
    rst_n = 1'b0;
    #1;
    check("R1 async reset releases", pull_low, 1'b0);
    check("R1 async reset stuck", stuck, 1'b0);
    run = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(2);
    check("R1 stays released after reset", pull_low, 1'b0);

    done = 1'b1;
    finish_run();
  end

endmodule